// File: doc/BRIEF.md
# Serial Systematic (15,11) Cyclic Encoder

This block turns an 11-bit information word into a 15-bit systematic codeword of the cyclic Hamming code built on the generator x^4 + x + 1. The information word arrives one bit per clock, highest-order bit first. Each bit goes two ways at once. It passes unchanged to the serial output, and it also enters a four-stage division register. That register holds the remainder of i(x)·x^4 divided by the generator. After the eleventh bit, an output selector switches from the data path to the division register. The four check bits then follow the information bits on the same serial line.

A one-cycle `start` pulse opens a word. A valid flag marks every output bit, and a one-cycle completion pulse follows the last check bit. A new `start` can be issued at any time. If it arrives while a word is still being produced, that word is abandoned. If it arrives in the cycle straight after the last check bit, the next word runs back to back with the previous one.

Top module: `cyclic_encoder`

## Requirements
- R1: While reset is applied and after it is released with no `start`, `codeOut`, `outValid` and `done` are all 0.
- R2: A `start` sampled high on a clock edge clears the division register. The highest-order information bit is sampled on the following edge, and one more bit on each of the next ten edges, for 11 bits in all.
- R3: Each information bit appears on `codeOut` one clock after it is sampled, in arrival order. The information word therefore forms codeword bits 14 down to 4.
- R4: Directly after the information bits, `codeOut` carries the 4 bits of the remainder of i(x)·x^4 modulo x^4+x+1, highest-order coefficient first. These form codeword bits 3 down to 0.
- R5: `outValid` is high in exactly the 15 cycles that carry codeword bits, and low at all other times.
- R6: `done` is high for exactly one cycle, the cycle after the one that carries check bit 0.
- R7: When no word is in progress, `codeOut` is 0 and `dataIn` has no effect on any output.
- R8: A `start` that arrives while information or check bits are still being produced abandons the current word. No `done` is produced for it, and the new word is encoded correctly from its first bit.
- R9: A `start` in the cycle after the last check bit still lets `done` pulse for the finished word. The new word's first bit is sampled on the next edge, so the two words run back to back.
- R10: While check bits are shifted out, the division feedback is off and the register fills with zeros from the low end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that opens a new word |
| dataIn | input | 1 | Serial information bit, highest order first |
| codeOut | output | 1 | Serial codeword bit |
| outValid | output | 1 | High while `codeOut` carries a codeword bit |
| done | output | 1 | One-cycle pulse after the last check bit |

## Verification
Two things can fall in the same cycle: the completion of a word and the `start` of the next one. The bench provokes this by raising `start` in the cycle right after the last check bit. It then requires two results. `done` must still pulse for the finished word, and the following codeword, including its first bit, must match the reference division. A second kind of collision is a `start` that lands inside the information phase or the check phase. For that case the bench requires that no early `done` appears and that the restarted word is correct. Every one of the 2048 information words is also compared, bit by bit, against a long-division reference.

// File: rtl/cyclic_encoder_pkg.sv
package cyclic_encoder_pkg;

  // Phase of the serial schedule
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_DATA  = 2'd1,
    PH_CHECK = 2'd2,
    PH_FIN   = 2'd3
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;     // wipe the division register
    logic shiftIn;   // consume an information bit
    logic shiftOut;  // emit a check bit
  } strobeT;

endpackage

// File: rtl/cyclic_encoder_ctrl.sv
module cyclic_encoder_ctrl
  import cyclic_encoder_pkg::*;
#(
  parameter int K = 11,
  parameter int R = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  output strobeT strobe,
  output logic   done
);

  localparam int MAXC = (K > R) ? K : R;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LAST_DATA  = CW'(K - 1);
  localparam logic [CW-1:0] LAST_CHECK = CW'(R - 1);

  phaseT         phase;
  logic [CW-1:0] cnt;
  logic          doneQ;

  // start has priority over any shift in its cycle
  always_comb begin
    strobe.clear    = start;
    strobe.shiftIn  = (phase == PH_DATA)  && !start;
    strobe.shiftOut = (phase == PH_CHECK) && !start;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      doneQ <= 1'b0;
    end else begin
      // completion is reported even if a new start lands in PH_FIN
      doneQ <= (phase == PH_FIN);
      if (start) begin
        phase <= PH_DATA;
        cnt   <= '0;
      end else begin
        unique case (phase)
          PH_DATA: begin
            if (cnt == LAST_DATA) begin
              phase <= PH_CHECK;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_CHECK: begin
            if (cnt == LAST_CHECK) begin
              phase <= PH_FIN;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_FIN:  phase <= PH_IDLE;
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  assign done = doneQ;

  // R6: a completion pulse only follows the finishing phase
  assert_done_after_fin_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> $past(phase == PH_FIN));

  // R6: the pulse lasts one cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R2: the bit counter stays inside the information length
  assert_data_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA) |-> (cnt <= LAST_DATA));

  // R8: a start always reopens the information phase from bit zero
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (phase == PH_DATA) && (cnt == '0));

endmodule

// File: rtl/cyclic_encoder_dp.sv
module cyclic_encoder_dp
  import cyclic_encoder_pkg::*;
#(
  parameter int          R    = 4,
  parameter logic [R-1:0] TAPS = 4'b0011  // generator coefficients x^0..x^(R-1)
) (
  input  logic   clk,
  input  logic   rstN,
  input  strobeT strobe,
  input  logic   dataIn,
  output logic   codeOut,
  output logic   outValid
);

  logic [R-1:0] remQ;
  logic [R-1:0] remNext;
  logic         feedBack;
  logic         codeQ;
  logic         validQ;

  // feedback is live only while information bits enter
  assign feedBack = strobe.shiftIn & (dataIn ^ remQ[R-1]);

  for (genvar i = 0; i < R; i++) begin : g_stage
    if (i == 0) begin : g_low
      assign remNext[i] = TAPS[i] & feedBack;
    end else begin : g_up
      assign remNext[i] = remQ[i-1] ^ (TAPS[i] & feedBack);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remQ   <= '0;
      codeQ  <= 1'b0;
      validQ <= 1'b0;
    end else begin
      if (strobe.clear) begin
        remQ <= '0;
      end else if (strobe.shiftIn || strobe.shiftOut) begin
        remQ <= remNext;
      end
      // output selector: data path, then divider, else quiet
      if (strobe.shiftIn) begin
        codeQ <= dataIn;
      end else if (strobe.shiftOut) begin
        codeQ <= remQ[R-1];
      end else begin
        codeQ <= 1'b0;
      end
      validQ <= strobe.shiftIn | strobe.shiftOut;
    end
  end

  assign codeOut  = codeQ;
  assign outValid = validQ;

  // R7: the line is quiet whenever no codeword bit is carried
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !validQ |-> !codeQ);

  // R10: zeros fill the register from the low end while check bits leave
  assert_zero_fill_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftOut |=> !remQ[0]);

  // R2: a start leaves an empty division register
  assert_clear_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (remQ == '0));

endmodule

// File: rtl/cyclic_encoder.sv
module cyclic_encoder
  import cyclic_encoder_pkg::*;
#(
  parameter int          K    = 11,
  parameter int          R    = 4,
  parameter logic [R-1:0] TAPS = 4'b0011
) (
  input  logic clk,
  input  logic rstN,
  input  logic start,
  input  logic dataIn,
  output logic codeOut,
  output logic outValid,
  output logic done
);

  strobeT strobe;

  cyclic_encoder_ctrl #(.K(K), .R(R)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .strobe (strobe),
    .done   (done)
  );

  cyclic_encoder_dp #(.R(R), .TAPS(TAPS)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .dataIn   (dataIn),
    .codeOut  (codeOut),
    .outValid (outValid)
  );

  // R5: valid output and completion never coincide
  assert_valid_done_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

endmodule

// File: tb/cyclic_encoder_bench.sv
module cyclic_encoder_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic dataIn = 1'b0;
  logic codeOut, outValid, done;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  cyclic_encoder u_cyclic_encoder (
    .clk(clk), .rstN(rstN), .start(start), .dataIn(dataIn),
    .codeOut(codeOut), .outValid(outValid), .done(done)
  );

  // Hand-worked vectors: information word and its codeword
  localparam int NV = 6;
  localparam logic [10:0] VIN [NV] = '{11'h000, 11'h001, 11'h002, 11'h400, 11'h555, 11'h7FF};
  localparam logic [14:0] VEXP[NV] = '{15'h0000, 15'h0013, 15'h0026, 15'h4009, 15'h555B, 15'h7FFF};

  task automatic check(input bit ok, input string req, input int got, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // Long-division reference of i(x)*x^4 by x^4+x+1
  function automatic logic [14:0] refCode(input logic [10:0] info);
    logic [14:0] v;
    v = {info, 4'b0000};
    for (int p = 14; p >= 4; p--)
      if (v[p]) v = v ^ (15'b10011 << (p - 4));
    return {info, v[3:0]};
  endfunction

  // Drives one word and collects its 15 output bits.
  // firstT==2 means start and the first bit were driven by the previous call.
  task automatic runWord(input logic [10:0] info, input int firstT,
                         input bit startAtEnd, input bit nextMsb,
                         output logic [14:0] code, output int nValid,
                         output bit doneOk);
    bit early;
    code = '0; nValid = 0; doneOk = 0; early = 0;
    if (firstT == 1) begin
      @(negedge clk); start = 1'b1; dataIn = 1'b0;
    end
    for (int t = firstT; t <= 17; t++) begin
      @(negedge clk);
      if (t >= 2 && t <= 16) begin
        code = {code[13:0], codeOut};
        if (outValid) nValid++;
        if (done) early = 1;
      end
      if (t == 17) doneOk = done && !early && !outValid;
      start  = (t == 16) ? startAtEnd : 1'b0;
      dataIn = (t <= 11) ? info[11 - t] : ((t == 17) ? nextMsb : 1'b0);
    end
  endtask

  task automatic judge(input logic [10:0] info, input logic [14:0] exp,
                       input logic [14:0] code, input int nValid, input bit doneOk,
                       input string tag);
    check(code[14:4] == exp[14:4], {"R3 info bits ", tag}, code[14:4], exp[14:4]);
    check(code[3:0] == exp[3:0],   {"R4 check bits ", tag}, code[3:0], exp[3:0]);
    check(nValid == 15,            {"R5 valid count ", tag}, nValid, 15);
    check(doneOk,                  {"R6 done pulse ", tag}, doneOk, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [14:0] code;
    int nv;
    bit dk;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({codeOut, outValid, done} == 3'b000, "R1 in reset", {codeOut, outValid, done}, 0);
    rstN = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check({codeOut, outValid, done} == 3'b000, "R1 after release", {codeOut, outValid, done}, 0);
    end

    // Table walk
    for (int k = 0; k < NV; k++) begin
      runWord(VIN[k], 1, 0, 0, code, nv, dk);
      judge(VIN[k], VEXP[k], code, nv, dk, "table");
    end

    // R7: idle, data toggling has no effect
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      check({codeOut, outValid, done} == 3'b000, "R7 idle quiet", {codeOut, outValid, done}, 0);
      dataIn = ~dataIn;
    end

    // R2 R3 R4: every information word against the reference
    for (int w = 0; w < 2048; w++) begin
      runWord(11'(w), 1, 0, 0, code, nv, dk);
      judge(11'(w), refCode(11'(w)), code, nv, dk, "sweep");
    end

    // R8: abort during the check phase
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; dataIn = 1'b1;
    repeat (13) begin @(negedge clk); dataIn = ~dataIn; end
    runWord(11'h555, 1, 0, 0, code, nv, dk);
    check(code == 15'h555B, "R8 abort in check", code, 15'h555B);
    check(dk && nv == 15, "R8 abort in check done/valid", {nv, dk}, {15, 1'b1});

    // R8: abort during the information phase
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; dataIn = 1'b1;
    repeat (4) @(negedge clk);
    runWord(11'h7FF, 1, 0, 0, code, nv, dk);
    check(code == 15'h7FFF, "R8 abort in data", code, 15'h7FFF);
    check(dk && nv == 15, "R8 abort in data done/valid", {nv, dk}, {15, 1'b1});

    // R9: start coincides with the finishing cycle, words back to back
    runWord(11'h001, 1, 1, 1'b1, code, nv, dk);
    check(code == 15'h0013 && dk, "R9 first word", code, 15'h0013);
    runWord(11'h400, 2, 1, 1'b1, code, nv, dk);
    check(code == 15'h4009 && dk, "R9 second word", code, 15'h4009);
    runWord(11'h555, 2, 0, 0, code, nv, dk);
    check(code == 15'h555B && dk && nv == 15, "R9 third word", code, 15'h555B);

    // R10: check bits after an all-zero-tail word keep the line quiet afterwards
    @(negedge clk);
    check({codeOut, outValid, done} == 3'b000, "R10 R7 quiet after", {codeOut, outValid, done}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule